// File: doc/BRIEF.md
# Monitor Channel Byte-Pair Transmitter

This block sends two-byte command messages over the monitor slot of a frame-based serial bus. A host hands it both bytes with a single load pulse. The block then waits until the bus shows an idle channel. After that it places each byte in the monitor slot frame after frame, and it uses the outgoing E bit to say that a fresh byte is present. It moves on only when the far end pulls the returning A bit low. The message closes with two frames in which E is left released.

The block sees one frame strobe per bus frame. On that strobe it samples the incoming A bit for the frame just ended, and it updates the outgoing slot contents for the next frame. An undriven bit is read as 1, as it would be with a pull-up. Separate enables mark when E and the data byte are really driven, which models the high-impedance state. If a byte is never acknowledged within a set number of frames, the message is dropped and an error pulse is raised.

Top module: `monitor_tx`

## Requirements
- R1: After reset the data enable and E enable are 0, the data output reads 0xFF, E reads 1, and busy, done and error are all 0.
- R2: A load pulse is taken only while busy is 0, and busy goes to 1 on the next clock. A load pulse while busy is 1 changes neither the bytes being sent nor busy.
- R3: A message starts only at a frame strobe that shows A high, and only if the previous strobe while idle also showed A high. A strobe that shows A low while idle restarts that two-frame count.
- R4: The first byte appears in the frame right after the starting strobe, with the data enabled and E driven to 0.
- R5: Each byte stays on the bus for at least two frames. An A low seen at the strobe that ends a byte's first frame is not taken as an acknowledge.
- R6: A byte is repeated, unchanged, in every frame until a strobe ends one of its second or later frames with A low.
- R7: In the first frame of the second byte, E is released (enable 0, reads 1). In each later frame of that byte, E is driven to 0.
- R8: After the second byte is acknowledged, both the data and E are released for exactly two frames. At the strobe that ends the second of those frames, done pulses for one clock and busy falls.
- R9: Suppose a byte has been on the bus for TIMEOUT_FRAMES frames (default 64) and the strobe that ends its last frame shows A high. Then data and E are released, error pulses for one clock, busy falls, and done stays 0.
- R10: If the strobe that would trigger the R9 timeout also shows A low, the acknowledge wins. The block moves on to the next byte and error stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_stb | input | 1 | One-clock pulse marking the end of a bus frame |
| a_in | input | 1 | Incoming A bit for the frame just ended (1 = inactive or undriven) |
| msg_load | input | 1 | Load pulse for a new message |
| msg_byte0 | input | 8 | First byte of the message |
| msg_byte1 | input | 8 | Second byte of the message |
| busy | output | 1 | High from an accepted load until the message ends or is aborted |
| msg_done | output | 1 | One-clock pulse after the end marker has been sent |
| msg_err | output | 1 | One-clock pulse when a message is aborted on timeout |
| mon_data | output | 8 | Monitor slot byte for the coming frame (0xFF when released) |
| mon_oe | output | 1 | Drive enable for mon_data |
| e_out | output | 1 | Outgoing E bit value (1 when released) |
| e_oe | output | 1 | Drive enable for e_out |

## Verification
The acknowledge check and the timeout check can fall on the same frame strobe. This happens when the far end pulls A low only at the strobe that ends the byte's last allowed frame. The bench holds A high for one frame short of the limit. It then gives the final strobe with A low and checks that the second byte appears with error still 0. A separate run gives the same final strobe with A high and checks that the block releases the bus, raises error and leaves done low.

// File: rtl/montx_pkg.sv
package montx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BYTE0 = 2'd1,
    ST_BYTE1 = 2'd2,
    ST_TAIL  = 2'd3
  } montx_state_e;

  localparam logic [7:0] RELEASED_BYTE = 8'hFF;

endpackage

// File: rtl/montx_idle_mon.sv
module montx_idle_mon #(
  parameter int IDLE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  input  logic frame_stb,
  input  logic a_in,
  output logic idle_ok
);

  localparam int IW = $clog2(IDLE_FRAMES + 1);
  localparam logic [IW-1:0] CNT_SAT = IW'(IDLE_FRAMES - 1);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!in_idle) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (frame_stb) begin
      cnt_en = 1'b1;
      if (!a_in) begin
        cnt_d = '0;
      end else if (cnt_q < CNT_SAT) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // The current strobe counts as the last of the required quiet frames.
  assign idle_ok = in_idle && frame_stb && a_in && (cnt_q >= CNT_SAT);

  AST_IDLE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT) else $error("idle count out of range"); // R3

  AST_IDLE_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !a_in) |=> (cnt_q == '0)) else $error("A low did not clear idle count"); // R3

endmodule

// File: rtl/montx_byte_timer.sv
module montx_byte_timer #(
  parameter int TIMEOUT_FRAMES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic frame_stb,
  output logic first_frame,
  output logic min_met,
  output logic expired
);

  localparam int TW = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_FRAMES);

  logic [TW-1:0] frm_q;
  logic [TW-1:0] frm_d;
  logic          frm_en;

  always_comb begin
    frm_en = 1'b0;
    frm_d  = frm_q;
    if (restart) begin
      frm_en = 1'b1;
      frm_d  = TW'(1);
    end else if (run && frame_stb && (frm_q < LIMIT)) begin
      frm_en = 1'b1;
      frm_d  = frm_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '0;
    end else if (frm_en) begin
      frm_q <= frm_d;
    end
  end

  assign first_frame = (frm_q == TW'(1));
  assign min_met     = (frm_q >= TW'(2));
  assign expired     = (frm_q >= LIMIT);

  AST_FRAME_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q <= LIMIT) else $error("frame count beyond timeout"); // R9

  AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> first_frame) else $error("restart did not mark first frame"); // R5

endmodule

// File: rtl/montx_ctrl.sv
module montx_ctrl
  import montx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_stb,
  input  logic         a_in,
  input  logic         msg_load,
  input  logic [7:0]   msg_byte0,
  input  logic [7:0]   msg_byte1,
  input  logic         idle_ok,
  input  logic         min_met,
  input  logic         expired,
  output montx_state_e state_q,
  output logic [7:0]   byte0_q,
  output logic [7:0]   byte1_q,
  output logic         tmr_restart,
  output logic         busy,
  output logic         done,
  output logic         err
);

  montx_state_e state_d;
  logic         busy_q, busy_d;
  logic         done_q, done_d;
  logic         err_q, err_d;
  logic         take_load;
  logic         ack_now;
  logic         tmo_now;
  logic         in_byte;

  assign take_load = msg_load && !busy_q;
  assign in_byte   = (state_q == ST_BYTE0) || (state_q == ST_BYTE1);
  assign ack_now   = in_byte && frame_stb && !a_in && min_met;
  assign tmo_now   = in_byte && frame_stb && !ack_now && expired;

  always_comb begin
    state_d     = state_q;
    busy_d      = busy_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    tmr_restart = 1'b0;
    if (take_load) begin
      busy_d = 1'b1;
    end
    unique case (state_q)
      ST_IDLE: begin
        if (busy_q && idle_ok) begin
          state_d     = ST_BYTE0;
          tmr_restart = 1'b1;
        end
      end
      ST_BYTE0, ST_BYTE1: begin
        if (ack_now) begin
          state_d     = (state_q == ST_BYTE0) ? ST_BYTE1 : ST_TAIL;
          tmr_restart = 1'b1;
        end else if (tmo_now) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          err_d   = 1'b1;
        end
      end
      ST_TAIL: begin
        if (frame_stb && min_met) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte0_q <= '0;
      byte1_q <= '0;
    end else if (take_load) begin
      byte0_q <= msg_byte0;
      byte1_q <= msg_byte1;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  AST_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && msg_load) |=> ($stable(byte0_q) && $stable(byte1_q))) else $error("load taken while busy"); // R2

  AST_START_NEEDS_A_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && frame_stb && !a_in) |=> (state_q == ST_IDLE)) else $error("start with A low"); // R3

  AST_FIRST_FRAME_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && frame_stb && !min_met && !expired) |=> $stable(state_q)) else $error("byte left after one frame"); // R5

  AST_STATE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb) |=> $stable(state_q)) else $error("state moved without strobe"); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R8

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)) else $error("done and error together"); // R9

  AST_ACK_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BYTE0 && frame_stb && !a_in && expired) |=> (state_q == ST_BYTE1 && !err_q)) else $error("timeout beat ack"); // R10

endmodule

// File: rtl/montx_drive.sv
module montx_drive
  import montx_pkg::*;
(
  input  montx_state_e state_q,
  input  logic         first_frame,
  input  logic [7:0]   byte0_q,
  input  logic [7:0]   byte1_q,
  output logic [7:0]   mon_data,
  output logic         mon_oe,
  output logic         e_out,
  output logic         e_oe
);

  always_comb begin
    mon_data = RELEASED_BYTE;
    mon_oe   = 1'b0;
    e_out    = 1'b1;
    e_oe     = 1'b0;
    unique case (state_q)
      ST_BYTE0: begin
        mon_data = byte0_q;
        mon_oe   = 1'b1;
        e_out    = 1'b0;
        e_oe     = 1'b1;
      end
      ST_BYTE1: begin
        mon_data = byte1_q;
        mon_oe   = 1'b1;
        if (!first_frame) begin
          e_out = 1'b0;
          e_oe  = 1'b1;
        end
      end
      default: begin
        mon_data = RELEASED_BYTE;
      end
    endcase
  end

  AST_E_DRIVEN_LOW: assert final (!e_oe || !e_out) else $error("E driven high"); // R7

endmodule

// File: rtl/monitor_tx.sv
module monitor_tx
  import montx_pkg::*;
#(
  parameter int IDLE_FRAMES    = 2,
  parameter int TIMEOUT_FRAMES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_stb,
  input  logic       a_in,
  input  logic       msg_load,
  input  logic [7:0] msg_byte0,
  input  logic [7:0] msg_byte1,
  output logic       busy,
  output logic       msg_done,
  output logic       msg_err,
  output logic [7:0] mon_data,
  output logic       mon_oe,
  output logic       e_out,
  output logic       e_oe
);

  logic [1:0]   rst_sync_q;
  logic         rst_ns;
  montx_state_e state_q;
  logic [7:0]   byte0_q;
  logic [7:0]   byte1_q;
  logic         idle_ok;
  logic         first_frame;
  logic         min_met;
  logic         expired;
  logic         tmr_restart;
  logic         in_idle;
  logic         tmr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  assign in_idle = (state_q == ST_IDLE);
  assign tmr_run = !in_idle;

  montx_idle_mon #(.IDLE_FRAMES(IDLE_FRAMES)) i_idle (
    .clk       (clk),
    .rst_n     (rst_ns),
    .in_idle   (in_idle),
    .frame_stb (frame_stb),
    .a_in      (a_in),
    .idle_ok   (idle_ok)
  );

  montx_byte_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) i_timer (
    .clk         (clk),
    .rst_n       (rst_ns),
    .restart     (tmr_restart),
    .run         (tmr_run),
    .frame_stb   (frame_stb),
    .first_frame (first_frame),
    .min_met     (min_met),
    .expired     (expired)
  );

  montx_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_ns),
    .frame_stb   (frame_stb),
    .a_in        (a_in),
    .msg_load    (msg_load),
    .msg_byte0   (msg_byte0),
    .msg_byte1   (msg_byte1),
    .idle_ok     (idle_ok),
    .min_met     (min_met),
    .expired     (expired),
    .state_q     (state_q),
    .byte0_q     (byte0_q),
    .byte1_q     (byte1_q),
    .tmr_restart (tmr_restart),
    .busy        (busy),
    .done        (msg_done),
    .err         (msg_err)
  );

  montx_drive i_drive (
    .state_q     (state_q),
    .first_frame (first_frame),
    .byte0_q     (byte0_q),
    .byte1_q     (byte1_q),
    .mon_data    (mon_data),
    .mon_oe      (mon_oe),
    .e_out       (e_out),
    .e_oe        (e_oe)
  );

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_ns)
    (!frame_stb && !msg_load) |=> ($stable(mon_data) && $stable(e_oe))) else $error("slot changed between strobes"); // R6

  AST_BUSY_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(busy) |-> (msg_done || msg_err)) else $error("busy fell without done or error"); // R8

endmodule

// File: tb/test_monitor_tx.sv
module test_monitor_tx;

  localparam int TMO = 64;
  localparam int NV  = 9;

  // {a_in, mon_oe, mon_data[7:0], e_oe, e_out, busy, done}
  localparam logic [13:0] VEC [NV] = '{
    14'b1_0_11111111_0_1_1_0,
    14'b1_1_00111100_1_0_1_0,
    14'b0_1_00111100_1_0_1_0,
    14'b1_1_00111100_1_0_1_0,
    14'b0_1_10100101_0_1_1_0,
    14'b1_1_10100101_1_0_1_0,
    14'b0_0_11111111_0_1_1_0,
    14'b1_0_11111111_0_1_1_0,
    14'b1_0_11111111_0_1_0_1
  };

  logic       clk;
  logic       rst_n;
  logic       frame_stb;
  logic       a_in;
  logic       msg_load;
  logic [7:0] msg_byte0;
  logic [7:0] msg_byte1;
  logic       busy;
  logic       msg_done;
  logic       msg_err;
  logic [7:0] mon_data;
  logic       mon_oe;
  logic       e_out;
  logic       e_oe;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  monitor_tx i_monitor_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .a_in      (a_in),
    .msg_load  (msg_load),
    .msg_byte0 (msg_byte0),
    .msg_byte1 (msg_byte1),
    .busy      (busy),
    .msg_done  (msg_done),
    .msg_err   (msg_err),
    .mon_data  (mon_data),
    .mon_oe    (mon_oe),
    .e_out     (e_out),
    .e_oe      (e_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic a);
    @(negedge clk);
    a_in      = a;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  task automatic load(input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    msg_byte0 = b0;
    msg_byte1 = b1;
    msg_load  = 1'b1;
    @(negedge clk);
    msg_load  = 1'b0;
  endtask

  function automatic logic [12:0] outs();
    return {mon_oe, mon_data, e_oe, e_out, busy, msg_done};
  endfunction

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; a_in = 1'b1;
    msg_load = 1'b0; msg_byte0 = '0; msg_byte1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 reset outputs", {19'd0, outs()}, {19'd0, 13'b0_11111111_0_1_0_0});
    check("R1 reset error", {31'd0, msg_err}, 32'd0);

    // R2 busy after load
    load(8'h3C, 8'hA5);
    check("R2 busy after load", {31'd0, busy}, 32'd1);

    // R3 R4 R5 R6 R7 R8 normal message from the vector table
    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][13]);
      check($sformatf("R4 R5 R6 R7 R8 vector %0d", i), {19'd0, outs()}, {19'd0, VEC[i][12:0]});
    end
    @(negedge clk);
    check("R8 done one cycle", {31'd0, msg_done}, 32'd0);

    // R3 A low while idle restarts the quiet count
    load(8'h11, 8'h22);
    frame(1'b1);
    frame(1'b0);
    check("R3 idle after A low", {31'd0, mon_oe}, 32'd0);
    frame(1'b1);
    check("R3 one quiet frame not enough", {31'd0, mon_oe}, 32'd0);
    frame(1'b1);
    check("R4 first byte data", {24'd0, mon_data}, 32'h11);
    check("R4 E driven low", {30'd0, e_oe, e_out}, 32'b10);

    // R2 load while busy is ignored
    load(8'h99, 8'h77);
    check("R2 busy held", {31'd0, busy}, 32'd1);
    check("R2 byte unchanged", {24'd0, mon_data}, 32'h11);
    frame(1'b1);
    frame(1'b0);
    check("R2 second byte kept", {24'd0, mon_data}, 32'h22);
    check("R7 E released first frame", {31'd0, e_oe}, 32'd0);
    frame(1'b0);
    check("R5 second byte no early ack", {24'd0, mon_data}, 32'h22);
    check("R7 E low on repeat", {30'd0, e_oe, e_out}, 32'b10);
    frame(1'b0);
    frame(1'b1);
    check("R8 still busy in tail", {31'd0, busy}, 32'd1);
    frame(1'b1);
    check("R8 done", {30'd0, msg_done, busy}, 32'b10);

    // R9 timeout with A high throughout
    load(8'h55, 8'h66);
    frame(1'b1);
    frame(1'b1);
    for (int k = 1; k < TMO; k++) frame(1'b1);
    check("R6 byte still repeated before limit", {23'd0, mon_oe, mon_data}, {23'd0, 1'b1, 8'h55});
    frame(1'b1);
    check("R9 abort outputs", {28'd0, mon_oe, e_oe, busy, msg_done}, 32'd0);
    check("R9 error pulse", {31'd0, msg_err}, 32'd1);
    @(negedge clk);
    check("R9 error one cycle", {31'd0, msg_err}, 32'd0);

    // R10 acknowledge on the final allowed frame wins
    load(8'hC3, 8'h5A);
    frame(1'b1);
    frame(1'b1);
    for (int k = 1; k < TMO; k++) frame(1'b1);
    frame(1'b0);
    check("R10 ack wins data", {23'd0, mon_oe, mon_data}, {23'd0, 1'b1, 8'h5A});
    check("R10 no error", {30'd0, msg_err, busy}, 32'b01);
    frame(1'b1);
    frame(1'b0);
    frame(1'b1);
    frame(1'b1);
    check("R10 message completes", {30'd0, msg_done, busy}, 32'b10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule